// File: doc/BRIEF.md
# Serial Control-Word Write Port for a Multiplexed Converter

This block takes the write side of a serial link to a multi-channel data-acquisition converter. While an active-low frame input is held low, a host shifts a short control word in on the falling edges of a serial clock, most significant bit first. The word holds a 3-bit channel address, a software conversion-start flag and a standby flag. The port decodes the word and drives the multiplexer address, the power-down flag, the enable for the hardware conversion-start input and two single-cycle events. One event requests a conversion and the other starts the settling timer.

The serial inputs are asynchronous to the block clock. They are first synchronised, and serial-clock falling edges are then detected in the block clock domain. An edge counter decides when the word commits. Address and start flag commit on the sixth falling edge, and the standby flag commits only on the seventh. A frame that ends early changes nothing, with one exception: if the start flag has already arrived as 1, a start request is still issued.

Top module: `scr_write_port`

## Requirements
- R1: After reset, chan_addr is 0, standby is 0, hw_start_en is 1, and sw_start and settle_start are 0.
- R2: Bits are taken on falling edges of sck while frm_n is low. The first five bits are, in order, address bit 2, address bit 1, address bit 0, the start flag and the standby flag. On the sixth falling edge of a frame, chan_addr takes the three address bits.
- R3: If frm_n rises before the sixth falling edge, chan_addr, standby and hw_start_en keep their values and settle_start does not pulse.
- R4: Each frame that reaches its sixth falling edge gives exactly one settle_start pulse. It also gives exactly one sw_start pulse when the start flag is 1, and none when it is 0.
- R5: If a frame ends after its fourth or fifth falling edge with the start flag received as 1, exactly one sw_start pulse occurs and the stored register is left unchanged. If the flag was 0, no pulse occurs.
- R6: standby takes the received standby flag only on the seventh falling edge of a frame. A frame of exactly six edges leaves standby unchanged.
- R7: hw_start_en is 0 while the stored start flag is 1, and returns to 1 after a complete write with the flag 0.
- R8: A stored start flag of 1 gives no further sw_start pulses between writes.
- R9: Falling edges after the seventh in a frame have no effect. The edge count restarts at zero for each new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock, asynchronous; idles high |
| frm_n | input | 1 | Active-low frame, asynchronous |
| sdi | input | 1 | Serial data, taken on falling sck edges |
| chan_addr | output | 3 | Multiplexer channel address |
| standby | output | 1 | Power-down request |
| hw_start_en | output | 1 | Enable for the hardware conversion-start input |
| sw_start | output | 1 | One-cycle software conversion request |
| settle_start | output | 1 | One-cycle trigger for the settling timer |

## Verification
On every cycle, the embedded assertions check the following:
- chan_addr and the start flag change only on a sixth-edge event, and standby changes only on a seventh-edge event.
- sw_start never stays high for two cycles in a row.
- The edge counter stays at its limit once saturated.
- Serial-clock falling edges are never reported on consecutive cycles.

Only the directed scenarios can show the following:
- The bit order, and the exact count of start and settle pulses per frame.
- That a cut-short frame with the start flag set still asks for a conversion.
- That extra edges and back-to-back frames leave the decoded values correct.

// File: rtl/scr_pkg.sv
// Shared constants and types for the serial control-word write port.
package scr_pkg;
    localparam int CW          = 5;   // bits carried in a control word
    localparam int FLAG_EDGE   = 4;   // edge on which the start flag arrives
    localparam int COMMIT_EDGE = 6;   // edge committing address and start flag
    localparam int STBY_EDGE   = 7;   // edge committing the standby flag
    localparam int CNT_W       = $clog2(STBY_EDGE + 1);

    typedef struct packed {
        logic [2:0] addr;
        logic       go;
        logic       pdn;
    } ctl_word_t;
endpackage

// File: rtl/scr_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes the inputs are levels that stay put for several clk cycles.
module scr_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/scr_edge.sv
// Detects falling serial-clock edges and rising frame edges in the clk domain.
// Assumes synchronised inputs; both idle high after reset.
module scr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic frm_s,
    output logic sck_fall,
    output logic frm_rise
);
    logic sck_q, frm_q;

    // Remember last cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b1;
            frm_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            frm_q <= frm_s;
        end
    end

    assign sck_fall = sck_q & ~sck_s;
    assign frm_rise = ~frm_q & frm_s;

    // R2
    fall_not_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_fall |=> !sck_fall);
endmodule

// File: rtl/scr_shifter.sv
// Counts falling edges inside a frame and captures the control word.
// Issues one-cycle events on the commit edge, the standby edge, and on an
// early frame end that carried a start flag of 1.
module scr_shifter
    import scr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_fall,
    input  logic             frm_s,
    input  logic             frm_rise,
    input  logic             sdi_s,
    output ctl_word_t        word,
    output logic             ev_commit,
    output logic             ev_pdn,
    output logic             ev_early_go
);
    localparam logic [CNT_W-1:0] C_FLAG   = CNT_W'(FLAG_EDGE);
    localparam logic [CNT_W-1:0] C_COMMIT = CNT_W'(COMMIT_EDGE);
    localparam logic [CNT_W-1:0] C_STBY   = CNT_W'(STBY_EDGE);
    localparam logic [CNT_W-1:0] C_BITS   = CNT_W'(CW);

    logic [CNT_W-1:0] cnt;
    logic [CW-1:0]    bits;
    logic [2:0]       idx;

    // Bit position written by the current edge (MSB first).
    always_comb idx = 3'(CW - 1) - 3'(cnt);

    // Edge counting, bit capture and event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            bits        <= '0;
            ev_commit   <= 1'b0;
            ev_pdn      <= 1'b0;
            ev_early_go <= 1'b0;
        end else begin
            ev_commit   <= 1'b0;
            ev_pdn      <= 1'b0;
            ev_early_go <= 1'b0;
            if (frm_s) begin
                cnt <= '0;
                if (frm_rise && cnt >= C_FLAG && cnt < C_COMMIT && bits[1])
                    ev_early_go <= 1'b1;
            end else if (sck_fall && cnt < C_STBY) begin
                cnt <= cnt + 1'b1;
                if (cnt < C_BITS) bits[idx] <= sdi_s;
                if (cnt == C_COMMIT - 1'b1) ev_commit <= 1'b1;
                if (cnt == C_STBY - 1'b1)   ev_pdn    <= 1'b1;
            end
        end
    end

    assign word = ctl_word_t'(bits);

    // R9
    cnt_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == C_STBY && !frm_s) |=> (cnt == C_STBY));
    // R6
    pdn_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_commit |-> !ev_pdn);
endmodule

// File: rtl/scr_regfile.sv
// Holds the committed control register and drives the start and settle events.
// Assumes events from the shifter are single-cycle pulses.
module scr_regfile
    import scr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ctl_word_t word,
    input  logic      ev_commit,
    input  logic      ev_pdn,
    input  logic      ev_early_go,
    output logic [2:0] addr_q,
    output logic      go_q,
    output logic      pdn_q,
    output logic      go_pulse,
    output logic      settle_pulse
);
    // Commit fields on their edges and form the output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q       <= '0;
            go_q         <= 1'b0;
            pdn_q        <= 1'b0;
            go_pulse     <= 1'b0;
            settle_pulse <= 1'b0;
        end else begin
            go_pulse     <= 1'b0;
            settle_pulse <= 1'b0;
            if (ev_commit) begin
                addr_q       <= word.addr;
                go_q         <= word.go;
                go_pulse     <= word.go;
                settle_pulse <= 1'b1;
            end
            if (ev_pdn)      pdn_q    <= word.pdn;
            if (ev_early_go) go_pulse <= 1'b1;
        end
    end

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_commit |=> $stable(addr_q) && $stable(go_q));
    // R6
    pdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_pdn |=> $stable(pdn_q));
    // R8
    single_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |=> !go_pulse);
endmodule

// File: rtl/scr_write_port.sv
// Top of the serial control-word write port: synchronises the serial pins,
// counts frame edges, and holds the decoded control register.
// Assumes sck runs at least several times slower than clk.
module scr_write_port
    import scr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       frm_n,
    input  logic       sdi,
    output logic [2:0] chan_addr,
    output logic       standby,
    output logic       hw_start_en,
    output logic       sw_start,
    output logic       settle_start
);
    logic [2:0] pins_s;
    logic       sck_fall, frm_rise;
    ctl_word_t  word;
    logic       ev_commit, ev_pdn, ev_early_go;
    logic       go_q;

    scr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sck, frm_n, sdi}), .q(pins_s));

    scr_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck_s(pins_s[2]), .frm_s(pins_s[1]),
        .sck_fall(sck_fall), .frm_rise(frm_rise));

    scr_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .frm_s(pins_s[1]),
        .frm_rise(frm_rise), .sdi_s(pins_s[0]), .word(word),
        .ev_commit(ev_commit), .ev_pdn(ev_pdn), .ev_early_go(ev_early_go));

    scr_regfile u_reg (
        .clk(clk), .rst_n(rst_n), .word(word), .ev_commit(ev_commit),
        .ev_pdn(ev_pdn), .ev_early_go(ev_early_go), .addr_q(chan_addr),
        .go_q(go_q), .pdn_q(standby), .go_pulse(sw_start),
        .settle_pulse(settle_start));

    assign hw_start_en = ~go_q;

    // R7
    hw_en_rises_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hw_start_en) |-> $past(ev_commit));
    // R4
    settle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        settle_start |=> !settle_start);
endmodule

// File: tb/scr_write_port_tb.sv
module scr_write_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b1, frm_n = 1'b1, sdi = 1'b0;
    logic [2:0] chan_addr;
    logic standby, hw_start_en, sw_start, settle_start;
    int checks = 0, errors = 0;
    int n_go = 0, n_settle = 0, cyc = 0;

    always #2 clk = ~clk;

    scr_write_port u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .frm_n(frm_n), .sdi(sdi),
        .chan_addr(chan_addr), .standby(standby), .hw_start_en(hw_start_en),
        .sw_start(sw_start), .settle_start(settle_start));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && sw_start) n_go <= n_go + 1;
        if (rst_n && settle_start) n_settle <= n_settle + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of n falling edges; bits after the fifth are driven to 1.
    task automatic frame(input logic [4:0] w, input int n);
        frm_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < n; i++) begin
            sck = 1'b1;
            sdi = (i < 5) ? w[4-i] : 1'b1;
            wait_clk(4);
            sck = 1'b0;
            wait_clk(4);
        end
        sck = 1'b1;
        wait_clk(4);
        frm_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic t_reset;
        chk("R1 addr", chan_addr, 0);
        chk("R1 standby", standby, 0);
        chk("R1 hw_start_en", hw_start_en, 1);
        chk("R1 pulses", n_go + n_settle, 0);
    endtask

    task automatic t_plain_write;
        int g = n_go, s = n_settle;
        frame(5'b101_0_0, 6);
        chk("R2 addr", chan_addr, 5);
        chk("R4 settle once", n_settle - s, 1);
        chk("R4 no go", n_go - g, 0);
        chk("R7 hw en", hw_start_en, 1);
    endtask

    task automatic t_go_write;
        int g = n_go, s = n_settle;
        frame(5'b011_1_0, 6);
        chk("R2 addr", chan_addr, 3);
        chk("R4 go once", n_go - g, 1);
        chk("R4 settle once", n_settle - s, 1);
        chk("R7 hw disabled", hw_start_en, 0);
        wait_clk(60);
        chk("R8 no repeat", n_go - g, 1);
    endtask

    task automatic t_standby;
        frame(5'b110_0_1, 6);
        chk("R6 six edges", standby, 0);
        chk("R2 addr", chan_addr, 6);
        chk("R7 hw re-enabled", hw_start_en, 1);
        frame(5'b110_0_1, 7);
        chk("R6 seven edges", standby, 1);
    endtask

    task automatic t_partial;
        int g = n_go, s = n_settle;
        frame(5'b001_0_0, 3);
        chk("R3 addr kept", chan_addr, 6);
        chk("R3 standby kept", standby, 1);
        chk("R3 no settle", n_settle - s, 0);
        chk("R3 no go", n_go - g, 0);
    endtask

    task automatic t_early_go;
        int g = n_go, s = n_settle;
        frame(5'b010_1_0, 4);
        chk("R5 go at 4", n_go - g, 1);
        chk("R5 addr kept", chan_addr, 6);
        chk("R5 hw en kept", hw_start_en, 1);
        frame(5'b010_1_0, 5);
        chk("R5 go at 5", n_go - g, 2);
        chk("R5 standby kept", standby, 1);
        chk("R5 no settle", n_settle - s, 0);
        frame(5'b010_0_0, 5);
        chk("R5 flag 0 no go", n_go - g, 2);
    endtask

    task automatic t_extra_edges;
        int s = n_settle;
        frame(5'b100_0_0, 10);
        chk("R9 addr", chan_addr, 4);
        chk("R9 standby", standby, 0);
        chk("R9 settle once", n_settle - s, 1);
        frame(5'b111_0_1, 7);
        chk("R9 next frame addr", chan_addr, 7);
        chk("R9 next frame standby", standby, 1);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_plain_write();
        t_go_write();
        t_standby();
        t_partial();
        t_early_go();
        t_extra_edges();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule